// File: doc/BRIEF.md
# Programmable clock output controller

This block generates two clock outputs for off-chip use. Output A passes the oscillator reference through a gate. Either a software enable bit or an external request pin can open the gate, so the oscillator clock can be handed to another device while the rest of the chip sleeps. Output B picks one of four source clocks, divides it by 1, 2, 4, 8 or 16, and runs only while both its own enable bit and a core-domain-active input are high. Each output has a programmable level that it holds while it is stopped.

All logic runs in one fast sampling clock `clk`. The source clocks and the oscillator are brought in through synchronisers, and their edges are found there. Each output is a registered level, so it can change only on a `clk` edge. Each output changes level only after a detected source edge. When an output stops, it first finishes the phase it is in. A new source, divider or idle level is taken up only after output B has parked. After parking, output B restarts from its idle phase on a clean source edge.

Top module: `clkout_ctrl`

## Requirements
- R1: While register 0 bit 0 is 1, clkout_a follows the oscillator, with high and low phases of the same length as the oscillator's.
- R2: req_in high opens output A on its own, with register 0 bit 0 at 0 and core_active low. Software enable and request are OR-combined.
- R3: A stopped output holds its idle level. For output A this is register 0 bit 1. For output B it is register 1 bit 6. The value 0 means low and 1 means high.
- R4: Register 1 bits [1:0] select the source of output B: the value k picks src_in[k].
- R5: Register 1 bits [4:2] set the divider of output B. Codes 0, 1, 2, 3 and 4 divide by 1, 2, 4, 8 and 16. Codes 5 to 7 divide by 1.
- R6: For every divide ratio and either idle level, the high and low phases of output B are equal (50% duty).
- R7: Output B runs only while core_active is high and register 1 bit 5 is 1. Otherwise it holds its idle level.
- R8: An output changes level only after an edge of its selected source, and it starts only on a source edge. No phase is shorter than half a source period.
- R9: A change of source, divider or idle level while output B runs takes effect only after the current phase completes and the output has parked. The output then restarts from its idle phase.
- R10: A write with wr_en high loads the register chosen by addr. rdata returns {6'b0, pol_a, en_a} at address 0 and {1'b0, pol_b, en_b, div[2:0], sel[1:0]} at address 1. All fields reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for all logic |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_in | input | 1 | Oscillator reference clock |
| src_in | input | NSRC | Candidate source clocks for output B |
| req_in | input | 1 | External request that opens output A |
| core_active | input | 1 | Core power domain is active |
| wr_en | input | 1 | Register write strobe |
| addr | input | 1 | Register address for write and readback |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Readback of the addressed register |
| clkout_a | output | 1 | Gated oscillator output |
| clkout_b | output | 1 | Selected, divided, domain-gated output |

## Verification
The path from a source pin to an output runs through the synchroniser, the edge register and the output register. That path adds the same fixed delay to every edge, so phase lengths in `clk` cycles equal N times the source half period exactly. The checks therefore compare phase lengths, not absolute edge times. After each configuration change the bench waits out at least two output periods, which covers the parking and the restart. It then pushes the expected phase lengths into a queue, and the monitor compares each completed phase against the head of that queue. Register readback is combinational, so it is sampled at the falling edge after a write. Idle levels are sampled over whole windows after the output has had a full phase to park.

// File: rtl/ckout_pkg.sv
package ckout_pkg;

   localparam int CK_SEL_W   = 2;
   localparam int CK_DIV_W   = 3;
   localparam int CK_MAX_DIV = 4;
   localparam int CK_CNT_W   = (CK_MAX_DIV > 1) ? CK_MAX_DIV - 1 : 1;

   typedef struct packed {
      logic                pol;
      logic                en;
      logic [CK_DIV_W-1:0] div;
      logic [CK_SEL_W-1:0] sel;
   } bcfg_t;

   localparam int CK_BCFG_W = $bits(bcfg_t);

   function automatic logic div_bypass(input logic [CK_DIV_W-1:0] code);
      return (code == '0) || (32'(code) > CK_MAX_DIV);
   endfunction

   function automatic logic [CK_CNT_W-1:0] div_half_m1(input logic [CK_DIV_W-1:0] code);
      if (div_bypass(code))
         return '0;
      return CK_CNT_W'((32'd1 << (32'(code) - 32'd1)) - 32'd1);
   endfunction

endpackage

// File: rtl/ckout_sync.sv
module ckout_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic lvl,
   output logic rise,
   output logic fall
);

   logic [STAGES-1:0] sh_q;
   logic              prev_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("ckout_sync needs at least two stages");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh_q   <= '0;
         prev_q <= 1'b0;
      end else begin
         sh_q   <= {sh_q[STAGES-2:0], d};
         prev_q <= sh_q[STAGES-1];
      end
   end

   assign lvl  = sh_q[STAGES-1];
   assign rise = lvl & ~prev_q;
   assign fall = ~lvl & prev_q;

endmodule

// File: rtl/ckout_srcmux.sv
module ckout_srcmux #(
   parameter int NSRC  = 4,
   parameter int SEL_W = 2
) (
   input  logic [NSRC-1:0]  lvl_v,
   input  logic [NSRC-1:0]  rise_v,
   input  logic [NSRC-1:0]  fall_v,
   input  logic [SEL_W-1:0] sel,
   output logic             lvl,
   output logic             rise,
   output logic             fall
);

   generate
      if (NSRC != (1 << SEL_W)) begin : g_bad_nsrc
         $error("source count must equal 2**SEL_W");
      end
   endgenerate

   assign lvl  = lvl_v[sel];
   assign rise = rise_v[sel];
   assign fall = fall_v[sel];

endmodule

// File: rtl/ckout_regs.sv
module ckout_regs #(
   parameter int DATA_W = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_en,
   input  logic                   addr,
   input  logic [DATA_W-1:0]      wdata,
   output logic [DATA_W-1:0]      rdata,
   output logic                   a_en,
   output logic                   a_pol,
   output ckout_pkg::bcfg_t       b_cfg
);
   import ckout_pkg::*;

   generate
      if (DATA_W < CK_BCFG_W + 1) begin : g_bad_width
         $error("data width too small for register fields");
      end
   endgenerate

   logic unused_wbits;
   assign unused_wbits = ^wdata[DATA_W-1:CK_BCFG_W];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         a_en  <= 1'b0;
         a_pol <= 1'b0;
         b_cfg <= '0;
      end else if (wr_en) begin
         if (!addr) begin
            a_en  <= wdata[0];
            a_pol <= wdata[1];
         end else begin
            b_cfg <= bcfg_t'(wdata[CK_BCFG_W-1:0]);
         end
      end
   end

   always_comb begin
      rdata = '0;
      if (!addr)
         rdata[1:0] = {a_pol, a_en};
      else
         rdata[CK_BCFG_W-1:0] = b_cfg;
   end

   assert_wr_b_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr) |=> (b_cfg == $past(wdata[CK_BCFG_W-1:0])));

   assert_wr_a_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !addr) |=> ({a_pol, a_en} == $past(wdata[1:0])));

endmodule

// File: rtl/ckout_lane.sv
module ckout_lane #(
   parameter int CNT_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             src_lvl,
   input  logic             src_rise,
   input  logic             src_fall,
   input  logic             want,
   input  logic             restart,
   input  logic             pol,
   input  logic             bypass,
   input  logic [CNT_W-1:0] half_m1,
   output logic             clk_out,
   output logic             parked
);

   logic             run_q, run_d;
   logic             phase_q, phase_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic             out_d;
   logic             go, stop, start_edge, cur_lvl;

   always_comb begin
      start_edge = bypass ? (pol ? src_fall : src_rise) : src_rise;
      cur_lvl    = bypass ? src_lvl : phase_q;
      go         = !run_q && want && !restart && start_edge;
      stop       = run_q && (!want || restart) && (cur_lvl == pol);
      run_d      = go || (run_q && !stop);

      phase_d = phase_q;
      cnt_d   = cnt_q;
      if (go) begin
         phase_d = pol;
         cnt_d   = '0;
      end else if (run_q && !bypass && src_rise) begin
         if (cnt_q == half_m1) begin
            phase_d = ~phase_q;
            cnt_d   = '0;
         end else begin
            cnt_d = cnt_q + 1'b1;
         end
      end

      if (!run_d)
         out_d = pol;
      else if (bypass)
         out_d = src_lvl;
      else
         out_d = phase_d;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q   <= 1'b0;
         phase_q <= 1'b0;
         cnt_q   <= '0;
         clk_out <= 1'b0;
      end else begin
         run_q   <= run_d;
         phase_q <= phase_d;
         cnt_q   <= cnt_d;
         clk_out <= out_d;
      end
   end

   assign parked = !run_q;

   assert_edge_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(clk_out) && ($past(pol) == $past(pol, 2))) |-> $past(src_rise || src_fall));

   assert_start_on_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(run_q) |-> $past(src_rise || src_fall));

   assert_park_at_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(run_q) |-> (clk_out == $past(pol)));

   assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (parked && $past(parked) && ($past(pol) == $past(pol, 2))) |-> $stable(clk_out));

endmodule

// File: rtl/clkout_ctrl.sv
module clkout_ctrl #(
   parameter int NSRC        = 4,
   parameter int SYNC_STAGES = 2,
   parameter int DATA_W      = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              osc_in,
   input  logic [NSRC-1:0]   src_in,
   input  logic              req_in,
   input  logic              core_active,
   input  logic              wr_en,
   input  logic              addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              clkout_a,
   output logic              clkout_b
);
   import ckout_pkg::*;

   localparam int SEL_W = CK_SEL_W;

   generate
      if (NSRC != (1 << SEL_W)) begin : g_bad_nsrc
         $error("NSRC must match the select field width");
      end
   endgenerate

   // ---------------- configuration ----------------
   logic  a_en, a_pol;
   bcfg_t reg_b, act_q;

   ckout_regs #(.DATA_W(DATA_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .rdata(rdata), .a_en(a_en), .a_pol(a_pol), .b_cfg(reg_b)
   );

   // ---------------- synchronisers ----------------
   logic [NSRC-1:0] s_lvl, s_rise, s_fall;
   logic            o_lvl, o_rise, o_fall;

   generate
      for (genvar k = 0; k < NSRC; k++) begin : g_src_sync
         ckout_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk(clk), .rst_n(rst_n), .d(src_in[k]),
            .lvl(s_lvl[k]), .rise(s_rise[k]), .fall(s_fall[k])
         );
      end
   endgenerate

   ckout_sync #(.STAGES(SYNC_STAGES)) u_osc_sync (
      .clk(clk), .rst_n(rst_n), .d(osc_in),
      .lvl(o_lvl), .rise(o_rise), .fall(o_fall)
   );

   // ---------------- output A ----------------
   logic a_parked;

   ckout_lane #(.CNT_W(CK_CNT_W)) u_lane_a (
      .clk(clk), .rst_n(rst_n),
      .src_lvl(o_lvl), .src_rise(o_rise), .src_fall(o_fall),
      .want(a_en | req_in), .restart(1'b0), .pol(a_pol),
      .bypass(1'b1), .half_m1('0),
      .clk_out(clkout_a), .parked(a_parked)
   );

   // ---------------- output B ----------------
   logic b_lvl, b_rise, b_fall, b_parked, b_restart, b_want;

   ckout_srcmux #(.NSRC(NSRC), .SEL_W(SEL_W)) u_mux (
      .lvl_v(s_lvl), .rise_v(s_rise), .fall_v(s_fall), .sel(act_q.sel),
      .lvl(b_lvl), .rise(b_rise), .fall(b_fall)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)
         act_q <= '0;
      else if (b_parked)
         act_q <= reg_b;
   end

   assign b_restart = {act_q.pol, act_q.div, act_q.sel} != {reg_b.pol, reg_b.div, reg_b.sel};
   assign b_want    = core_active & reg_b.en;

   ckout_lane #(.CNT_W(CK_CNT_W)) u_lane_b (
      .clk(clk), .rst_n(rst_n),
      .src_lvl(b_lvl), .src_rise(b_rise), .src_fall(b_fall),
      .want(b_want), .restart(b_restart), .pol(act_q.pol),
      .bypass(div_bypass(act_q.div)), .half_m1(div_half_m1(act_q.div)),
      .clk_out(clkout_b), .parked(b_parked)
   );

   assert_cfg_parked_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(act_q) |-> $past(b_parked));

   assert_b_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(b_parked) |-> $past(core_active && reg_b.en));

   assert_a_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(a_parked) |-> $past(a_en || req_in));

endmodule

// File: tb/tb_clkout_ctrl.sv
module tb_clkout_ctrl;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       osc_in;
   logic [3:0] src_in;
   logic       req_in, core_active, wr_en, addr;
   logic [7:0] wdata, rdata;
   logic       clkout_a, clkout_b;

   always #4 clk = ~clk;

   clkout_ctrl dut (
      .clk(clk), .rst_n(rst_n), .osc_in(osc_in), .src_in(src_in),
      .req_in(req_in), .core_active(core_active), .wr_en(wr_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .clkout_a(clkout_a), .clkout_b(clkout_b)
   );

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 0;

   // source half periods in clk cycles: src0..src3, then oscillator
   int hp[5] = '{2, 3, 4, 5, 3};
   int sc[5] = '{0, 0, 0, 0, 0};

   initial begin
      src_in = '0;
      osc_in = 1'b0;
      forever begin
         @(negedge clk);
         for (int k = 0; k < 5; k++) begin
            sc[k]++;
            if (sc[k] == hp[k]) begin
               sc[k] = 0;
               if (k < 4) src_in[k] = ~src_in[k];
               else       osc_in    = ~osc_in;
            end
         end
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // ---------------- scoreboard ----------------
   int    qa[$];
   int    qb[$];
   string tag_a = "", tag_b = "";
   bit    st_a = 0, st_b = 0;
   int    len_a = 0, len_b = 0;
   logic  prev_a = 1'b0, prev_b = 1'b0;
   bit    trk_b = 0, seen_b = 0;
   int    min_b = 1000;

   always @(negedge clk) begin
      if (rst_n) begin
         len_a++;
         len_b++;
         if (clkout_a !== prev_a) begin
            if (st_a && qa.size() > 0) begin
               int e;
               e = qa.pop_front();
               check(len_a == e, tag_a, len_a, e);
            end
            st_a   = 1;
            len_a  = 0;
            prev_a = clkout_a;
         end
         if (clkout_b !== prev_b) begin
            if (st_b && qb.size() > 0) begin
               int e;
               e = qb.pop_front();
               check(len_b == e, tag_b, len_b, e);
            end
            if (trk_b && seen_b && len_b < min_b) min_b = len_b;
            if (trk_b) seen_b = 1;
            st_b   = 1;
            len_b  = 0;
            prev_b = clkout_b;
         end
      end
   end

   task automatic expect_a(input int len, input int n, input string req);
      @(posedge clk);
      tag_a = req;
      st_a  = 0;
      repeat (n) qa.push_back(len);
      while (qa.size() != 0) @(posedge clk);
   endtask

   task automatic expect_b(input int len, input int n, input string req);
      @(posedge clk);
      tag_b = req;
      st_b  = 0;
      repeat (n) qb.push_back(len);
      while (qb.size() != 0) @(posedge clk);
   endtask

   task automatic wr(input logic a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1;
      addr  = a;
      wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd_check(input logic a, input logic [7:0] exp, input string req);
      @(negedge clk);
      addr = a;
      #1;
      check(rdata == exp, req, int'(rdata), int'(exp));
   endtask

   task automatic hold_check(input bit which_b, input logic lvl, input int n, input string req);
      int bad = 0;
      logic v;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         v = which_b ? clkout_b : clkout_a;
         if (v !== lvl) bad++;
      end
      check(bad == 0, req, bad, 0);
   endtask

   task automatic settle(input int n);
      repeat (n) @(posedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0;
      req_in = 1'b0;
      core_active = 1'b0;
      wr_en = 1'b0;
      addr = 1'b0;
      wdata = '0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;

      // reset state (R10, R3)
      @(negedge clk);
      check(clkout_a == 1'b0, "R3 reset a", int'(clkout_a), 0);
      check(clkout_b == 1'b0, "R3 reset b", int'(clkout_b), 0);
      rd_check(1'b0, 8'h00, "R10 reset reg0");
      rd_check(1'b1, 8'h00, "R10 reset reg1");

      // R1: software enable on output A
      wr(1'b0, 8'h01);
      settle(30);
      expect_a(3, 4, "R1 osc phases");
      rd_check(1'b0, 8'h01, "R10 reg0 readback");

      // R3: idle level high on output A
      wr(1'b0, 8'h02);
      settle(20);
      hold_check(1'b0, 1'b1, 40, "R3 a idle high");

      // R2: request alone, domain off
      wr(1'b0, 8'h00);
      settle(10);
      req_in = 1'b1;
      settle(30);
      expect_a(3, 4, "R2 request phases");
      req_in = 1'b0;
      settle(20);
      hold_check(1'b0, 1'b0, 30, "R2 request released");

      // R7: enabled but domain inactive, then active
      wr(1'b1, 8'h20);
      hold_check(1'b1, 1'b0, 50, "R7 domain off holds idle");
      rd_check(1'b1, 8'h20, "R10 reg1 readback");
      core_active = 1'b1;
      settle(30);
      expect_b(2, 4, "R7 domain on runs");

      // R5: every divider code on src0 (half period 2), changed while running
      trk_b = 1;
      seen_b = 0;
      min_b = 1000;
      for (int c = 1; c < 8; c++) begin
         int nd;
         nd = (c <= 4) ? (1 << c) : 1;
         wr(1'b1, 8'h20 | 8'(c << 2));
         settle(8 * nd + 60);
         expect_b(2 * nd, 4, "R5 divider code");
      end
      rd_check(1'b1, 8'h3C, "R10 reg1 div field");

      // R4: source select with divide by 1
      for (int s = 1; s < 4; s++) begin
         wr(1'b1, 8'h20 | 8'(s));
         settle(60);
         expect_b(hp[s], 4, "R4 source select");
      end
      trk_b = 0;
      check(min_b >= 2, "R8 shortest phase", min_b, 2);

      // R6: duty with idle high, several ratios
      wr(1'b1, 8'h6F);
      settle(200);
      expect_b(40, 4, "R6 div8 src3 idle high");
      wr(1'b1, 8'h65);
      settle(60);
      expect_b(6, 4, "R6 div2 src1 idle high");
      wr(1'b1, 8'h33);
      settle(400);
      expect_b(80, 4, "R6 div16 src3");

      // R9: change while in the active (high) phase completes that phase
      begin
         int held = 0;
         while (clkout_b !== 1'b0) @(negedge clk);
         while (clkout_b !== 1'b1) @(negedge clk);
         repeat (10) @(negedge clk);
         wr(1'b1, 8'h20);
         while (clkout_b === 1'b1 && held < 200) begin
            @(negedge clk);
            held++;
         end
         check(held >= 60, "R9 phase completed before switch", held, 60);
         settle(40);
         expect_b(2, 4, "R9 new config after restart");
      end

      // R3: output B idle high once the domain goes off
      wr(1'b1, 8'h60);
      settle(40);
      core_active = 1'b0;
      settle(30);
      hold_check(1'b1, 1'b1, 40, "R3 b idle high");

      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule